// File: doc/BRIEF.md
# Banked Data Space Address Decoder

This block sits between a small Harvard-style microcontroller core and its 256-byte data space. Each request gives an 8-bit address and one of four addressing modes. The block turns these into an effective address and routes the read or write to one of four regions:

- an empty low region;
- a 64-byte window into a larger banked store;
- general-purpose RAM;
- a page of peripheral control registers.

The top peripheral byte is the core's accumulator. The first four RAM bytes are the index and scratch registers. A request can reach them through a 2-bit short select. The two index registers can also supply the address for register-indirect accesses.

The request side is a valid/ready stream. `req_ready` is held high at all times, so the block never applies back-pressure. A request is taken on every cycle where `req_valid` is high. Read data comes back combinationally in the same cycle. A write commits at the clock edge that ends that cycle. The bank-select register lives in the peripheral page and positions the window. The peripheral page beyond the bank and accumulator bytes is a plain register stub.

Top module: `bank_data_decoder`

## Requirements
- R1: A read of an effective address in 0x00..0x3F returns 0xFF. A write there changes no state.
- R2: `rsp_decerr` is high in the single cycle after an accepted read of 0x00..0x3F. It is low after any other accepted request or idle cycle.
- R3: An access to 0x40..0x7F reaches store entry bank*64 + (address - 0x40), where bank is the current bank select. The default configuration has 8 banks.
- R4: The bank select is at address 0xC8 and resets to 0. A write keeps the low log2(banks) data bits. A read returns them zero-extended, and `bank_q` shows them. The next accepted request already uses the new bank.
- R5: Addresses 0x80..0xBF are 64 bytes of read/write RAM.
- R6: Addresses 0xC0..0xFE other than 0xC8 are read/write stub registers that reset to 0x00.
- R7: Address 0xFF is the accumulator. It resets to 0, reads and writes it, and is shown on `acc_q`.
- R8: In mode 1 (short register), the effective address is 0x80 + `req_addr[1:0]`. Bits 7..2 of `req_addr` are ignored.
- R9: In mode 2, the effective address is the byte at 0x80 (X). In mode 3, it is the byte at 0x81 (Y). Mode 0 uses `req_addr` directly.
- R10: `req_ready` is always high. With `req_valid` low, `rsp_rdata` is 0x00 and no state changes, even if `req_write` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (constant high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 absolute, 1 short register, 2 indirect X, 3 indirect Y |
| req_addr | input | 8 | Address, or register select in mode 1 |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Same-cycle read data |
| rsp_decerr | output | 1 | Read of the empty region, one cycle late |
| bank_q | output | 3 | Current bank select |
| acc_q | output | 8 | Accumulator value |

## Verification
Read data is combinational, so the bench drives each request just after a falling edge and samples `rsp_rdata` 1 ns later, within the same cycle. Writes, including bank-select writes, take effect at the next rising edge. They are checked by a read issued on the following cycle, which also confirms that a new bank applies immediately. `rsp_decerr` passes through one register, so it is sampled 1 ns after the rising edge that ends the read. The bench sweeps every address of each region and every bank, and computes expected contents from the address and bank arithmetic.

// File: rtl/bdd_pkg.sv
package bdd_pkg;
  typedef enum logic [1:0] {
    MODE_ABS   = 2'd0,
    MODE_SHORT = 2'd1,
    MODE_IND_X = 2'd2,
    MODE_IND_Y = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_WIN    = 2'd1,
    RGN_RAM    = 2'd2,
    RGN_PERIPH = 2'd3
  } region_e;

  localparam int          PAGE_BYTES = 64;
  localparam int          PAGE_AW    = 6;
  localparam logic [7:0]  RAM_BASE   = 8'h80;
endpackage

// File: rtl/bdd_addr_gen.sv
module bdd_addr_gen
  import bdd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [7:0] addr,
  input  logic [7:0] x_val,
  input  logic [7:0] y_val,
  output logic [7:0] eff,
  output region_e    region
);
  always_comb begin
    unique case (amode_e'(mode))
      MODE_SHORT: eff = RAM_BASE | {6'd0, addr[1:0]};
      MODE_IND_X: eff = x_val;
      MODE_IND_Y: eff = y_val;
      default:    eff = addr;
    endcase
  end

  assign region = region_e'(eff[7:6]);

  // R8: short mode always lands in the four-register alias block
  a_r8_short_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (region == RGN_RAM && eff[5:2] == 4'd0));
endmodule

// File: rtl/bdd_ram.sv
module bdd_ram
  import bdd_pkg::*;
(
  input  logic               clk,
  input  logic               we,
  input  logic [PAGE_AW-1:0] waddr,
  input  logic [7:0]         wdata,
  input  logic [PAGE_AW-1:0] raddr,
  output logic [7:0]         rdata,
  output logic [7:0]         x_q,
  output logic [7:0]         y_q
);
  logic [7:0] mem [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
  assign x_q   = mem[0];
  assign y_q   = mem[1];
endmodule

// File: rtl/bdd_store.sv
module bdd_store
  import bdd_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [BANK_W-1:0]  bank,
  input  logic [PAGE_AW-1:0] offset,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);
  localparam int DEPTH = BANKS * PAGE_BYTES;
  localparam int AW    = BANK_W + PAGE_AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] idx;

  assign idx = {bank, offset};

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/bdd_periph.sv
module bdd_periph
  import bdd_pkg::*;
#(
  parameter int         BANK_W    = 3,
  parameter logic [7:0] BANK_ADDR = 8'hC8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PAGE_AW-1:0] offset,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [BANK_W-1:0]  bank_q,
  output logic [7:0]         acc_q
);
  localparam logic [PAGE_AW-1:0] BANK_OFS = BANK_ADDR[PAGE_AW-1:0];
  localparam logic [PAGE_AW-1:0] ACC_OFS  = '1;

  logic [7:0]        stub [PAGE_BYTES];
  logic [BANK_W-1:0] bank_r;
  logic [7:0]        acc_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) stub[i] <= '0;
      bank_r <= '0;
      acc_r  <= '0;
    end else if (we) begin
      if (offset == ACC_OFS)       acc_r        <= wdata;
      else if (offset == BANK_OFS) bank_r       <= wdata[BANK_W-1:0];
      else                         stub[offset] <= wdata;
    end
  end

  always_comb begin
    if (offset == ACC_OFS)       rdata = acc_r;
    else if (offset == BANK_OFS) rdata = {{(8-BANK_W){1'b0}}, bank_r};
    else                         rdata = stub[offset];
  end

  assign bank_q = bank_r;
  assign acc_q  = acc_r;

  // R4: the bank select moves only after a write to its own address
  a_r4_bank_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(we && offset == BANK_OFS));

  // R7: the accumulator moves only after a write to the top address
  a_r7_acc_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(we && offset == ACC_OFS));
endmodule

// File: rtl/bank_data_decoder.sv
module bank_data_decoder
  import bdd_pkg::*;
#(
  parameter int         BANKS      = 8,
  parameter logic [7:0] BANK_ADDR  = 8'hC8,
  parameter logic [7:0] UNIMPL_VAL = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [1:0]                 req_mode,
  input  logic [7:0]                 req_addr,
  input  logic [7:0]                 req_wdata,
  output logic [7:0]                 rsp_rdata,
  output logic                       rsp_decerr,
  output logic [$clog2(BANKS)-1:0]   bank_q,
  output logic [7:0]                 acc_q
);
  localparam int BANK_W = $clog2(BANKS);

  logic [7:0]  eff;
  region_e     region;
  logic [7:0]  x_val, y_val;
  logic [7:0]  ram_rd, win_rd, per_rd;
  logic        wr, ram_we, win_we, per_we;
  logic        decerr_q;

  assign req_ready = 1'b1;
  assign wr        = req_valid && req_write;
  assign ram_we    = wr && (region == RGN_RAM);
  assign win_we    = wr && (region == RGN_WIN);
  assign per_we    = wr && (region == RGN_PERIPH);

  bdd_addr_gen u_agen (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (req_mode),
    .addr   (req_addr),
    .x_val  (x_val),
    .y_val  (y_val),
    .eff    (eff),
    .region (region)
  );

  bdd_ram u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (eff[PAGE_AW-1:0]),
    .wdata (req_wdata),
    .raddr (eff[PAGE_AW-1:0]),
    .rdata (ram_rd),
    .x_q   (x_val),
    .y_q   (y_val)
  );

  bdd_store #(.BANKS(BANKS), .BANK_W(BANK_W)) u_store (
    .clk    (clk),
    .we     (win_we),
    .bank   (bank_q),
    .offset (eff[PAGE_AW-1:0]),
    .wdata  (req_wdata),
    .rdata  (win_rd)
  );

  bdd_periph #(.BANK_W(BANK_W), .BANK_ADDR(BANK_ADDR)) u_periph (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (per_we),
    .offset (eff[PAGE_AW-1:0]),
    .wdata  (req_wdata),
    .rdata  (per_rd),
    .bank_q (bank_q),
    .acc_q  (acc_q)
  );

  always_comb begin
    if (!req_valid) rsp_rdata = '0;
    else begin
      unique case (region)
        RGN_WIN:    rsp_rdata = win_rd;
        RGN_RAM:    rsp_rdata = ram_rd;
        RGN_PERIPH: rsp_rdata = per_rd;
        default:    rsp_rdata = UNIMPL_VAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) decerr_q <= 1'b0;
    else        decerr_q <= req_valid && !req_write && (region == RGN_NONE);
  end

  assign rsp_decerr = decerr_q;

  // R2: the flag follows only a read whose effective address was in the empty region
  a_r2_decerr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_decerr |-> $past(req_valid && !req_write && eff[7:6] == 2'b00));

  // R1: reads of the empty region return the fill value
  a_r1_unimpl_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && eff < 8'h40) |-> (rsp_rdata == UNIMPL_VAL));

  // R10: idle cycles present zero read data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (rsp_rdata == 8'h00));
endmodule

// File: tb/bank_data_decoder_tb.sv
`timescale 1ns/1ps
module bank_data_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready;
  logic [7:0] rsp_rdata;
  logic       rsp_decerr;
  logic [2:0] bank_q;
  logic [7:0] acc_q;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bank_data_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_decerr(rsp_decerr),
    .bank_q(bank_q), .acc_q(acc_q)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] m, input logic [7:0] a,
                        input logic [7:0] d, output logic [7:0] rd, output logic de);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_mode = m; req_addr = a; req_wdata = d;
    #1 rd = rsp_rdata;
    @(posedge clk);
    #1 de = rsp_decerr;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  function automatic logic [7:0] win_val(input int b, input int o);
    return 8'((b * 64 + o) * 7 + 3);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       de;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state (R4, R7, R2, R10)
    chk("R4 bank reset", {5'd0, bank_q}, 8'h00);
    chk("R7 acc reset", acc_q, 8'h00);
    chk("R2 decerr reset", {7'd0, rsp_decerr}, 8'h00);
    chk("R10 ready", {7'd0, req_ready}, 8'h01);
    chk("R10 idle rdata", rsp_rdata, 8'h00);
    // R6 reset sweep of the peripheral page
    for (int a = 8'hC0; a <= 8'hFF; a++) begin
      access(1'b0, 2'd0, 8'(a), 8'h00, rd, de);
      chk("R6 periph reset", rd, 8'h00);
    end
    // R1 / R2 empty region sweep
    for (int a = 0; a < 64; a++) begin
      access(1'b1, 2'd0, 8'(a), 8'(a ^ 8'h33), rd, de);
      chk("R2 no flag on write", {7'd0, de}, 8'h00);
      access(1'b0, 2'd0, 8'(a), 8'h00, rd, de);
      chk("R1 unimpl read", rd, 8'hFF);
      chk("R2 decerr after read", {7'd0, de}, 8'h01);
    end
    // R5 RAM sweep, also checks flag drops after one cycle (R2)
    for (int a = 8'h80; a < 8'hC0; a++)
      access(1'b1, 2'd0, 8'(a), 8'(a ^ 8'h5A), rd, de);
    for (int a = 8'h80; a < 8'hC0; a++) begin
      access(1'b0, 2'd0, 8'(a), 8'h00, rd, de);
      chk("R5 ram readback", rd, 8'(a ^ 8'h5A));
      chk("R2 flag low on ram read", {7'd0, de}, 8'h00);
    end
    // R3 / R4 fill every bank through the window
    for (int b = 0; b < 8; b++) begin
      access(1'b1, 2'd0, 8'hC8, 8'(b) | 8'hF8, rd, de);
      access(1'b0, 2'd0, 8'hC8, 8'h00, rd, de);
      chk("R4 bank readback", rd, 8'(b));
      chk("R4 bank_q", {5'd0, bank_q}, 8'(b));
      for (int o = 0; o < 64; o++)
        access(1'b1, 2'd0, 8'(64 + o), win_val(b, o), rd, de);
    end
    for (int b = 7; b >= 0; b--) begin
      access(1'b1, 2'd0, 8'hC8, 8'(b), rd, de);
      for (int o = 0; o < 64; o++) begin
        access(1'b0, 2'd0, 8'(64 + o), 8'h00, rd, de);
        chk("R3 window readback", rd, win_val(b, o));
      end
    end
    // R6 stub registers
    for (int a = 8'hC0; a < 8'hFF; a++)
      if (a != 8'hC8) access(1'b1, 2'd0, 8'(a), 8'(a * 3), rd, de);
    for (int a = 8'hC0; a < 8'hFF; a++)
      if (a != 8'hC8) begin
        access(1'b0, 2'd0, 8'(a), 8'h00, rd, de);
        chk("R6 stub readback", rd, 8'(a * 3));
      end
    access(1'b0, 2'd0, 8'hC8, 8'h00, rd, de);
    chk("R6 stub writes left bank", rd, 8'h00);
    // R7 accumulator
    access(1'b1, 2'd0, 8'hFF, 8'h3C, rd, de);
    #1 chk("R7 acc_q", acc_q, 8'h3C);
    access(1'b0, 2'd0, 8'hFF, 8'h00, rd, de);
    chk("R7 acc read", rd, 8'h3C);
    // R8 short register aliases
    for (int s = 0; s < 4; s++) begin
      access(1'b1, 2'd1, 8'(s) | 8'hA4, 8'(8'hE0 + s), rd, de);
      access(1'b0, 2'd0, 8'(8'h80 + s), 8'h00, rd, de);
      chk("R8 short write lands in RAM", rd, 8'(8'hE0 + s));
      access(1'b0, 2'd1, 8'(s) | 8'h5C, 8'h00, rd, de);
      chk("R8 short read", rd, 8'(8'hE0 + s));
    end
    // R9 indirect modes
    access(1'b1, 2'd0, 8'h80, 8'h90, rd, de);
    access(1'b1, 2'd2, 8'h00, 8'h77, rd, de);
    access(1'b0, 2'd0, 8'h90, 8'h00, rd, de);
    chk("R9 indirect X write", rd, 8'h77);
    access(1'b1, 2'd0, 8'h81, 8'h45, rd, de);
    access(1'b0, 2'd3, 8'hEE, 8'h00, rd, de);
    chk("R9 indirect Y window read", rd, win_val(0, 5));
    access(1'b1, 2'd0, 8'h80, 8'h20, rd, de);
    access(1'b0, 2'd2, 8'hB0, 8'h00, rd, de);
    chk("R9 indirect X to empty", rd, 8'hFF);
    chk("R2 flag via indirect", {7'd0, de}, 8'h01);
    // R10 writes without valid are dropped
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b1; req_mode = 2'd0; req_addr = 8'h85; req_wdata = 8'h00;
    #1 chk("R10 idle rdata", rsp_rdata, 8'h00);
    @(posedge clk);
    #1 chk("R2 no flag when idle", {7'd0, rsp_decerr}, 8'h00);
    access(1'b0, 2'd0, 8'h85, 8'h00, rd, de);
    chk("R10 no write when idle", rd, 8'(8'h85 ^ 8'h5A));
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule